// File: doc/BRIEF.md
# Single-Bus Register Transfer Datapath

This block is the data half of a small processor in which every transfer between storage elements crosses one shared internal bus. It holds four general registers, a program counter, an instruction register, an ALU operand latch (Y), an ALU result register (Z), and an address/data register pair that faces external memory. An external sequencer drives one out-enable bit per bus source, one in-enable bit per bus sink, the ALU operation, the operand select and the memory request strobes. Each micro-step of an instruction is then one clock cycle of enable settings. A three-step add runs as source-to-Y, then second-source-with-Y-into-Z, then Z-to-destination.

The ALU is combinational. Its B operand is the bus and its A operand is either Y or the constant 4, which lets the program counter advance with no extra adder. Memory is reached through a small state machine with three states: `MS_IDLE`, `MS_READ` and `MS_WRITE`. `MS_IDLE` goes to `MS_READ` on a read request and to `MS_WRITE` on a write request. Each access state stays put until the memory reports completion, then returns to `MS_IDLE` and the block raises a one-cycle done pulse. Latency is therefore whatever the memory needs.

The bus is a gated OR of the enabled sources rather than real tri-states. When more than one source is enabled, a conflict flag rises.

Top module: `sbus_datapath`

## Requirements
- R1: After synchronous reset, every register (R0..R3, PC, IR, Y, Z, MAR, MDR) reads zero, both flags are 0, the memory machine is idle, and mem_busy, mem_done, mem_read and mem_write are 0.
- R2: A sink loads the bus value at the rising edge only when its in_en bit is 1, and every other sink holds. The in_en bits are: 0..3 = R0..R3, 4 = PC, 5 = IR, 6 = Y, 7 = Z, 8 = MAR, 9 = MDR.
- R3: With exactly one out_en bit set, bus_value equals that source. With none set, it is zero. The out_en bits are: 0..3 = R0..R3, 4 = PC, 5 = IR, 6 = Z, 7 = MDR.
- R4: When two or more out_en bits are set, bus_conflict is 1 and bus_value is the bitwise OR of the enabled sources. Otherwise bus_conflict is 0.
- R5: The ALU operand A is Y when sel_const4 is 0 and the constant 4 when it is 1. Operand B is the bus. The alu_op codes are: 0 add (A+B), 1 subtract (A−B), 2 AND, 3 OR, 4 pass B. Z captures the result only when in_en[7] is 1.
- R6: On a Z load, flag_neg takes result bit 31 and flag_zero is set when the result is zero. Both flags hold in every other cycle.
- R7: A rd_req in idle drives mem_read from the next cycle until the cycle in which mem_mfc is seen high. At that edge MDR takes mem_rdata. mem_done is then high for exactly one cycle, and mem_busy falls at the same time.
- R8: A wr_req in idle drives mem_write with mem_addr = MAR and mem_wdata = MDR until mem_mfc is seen high. The number of mem_write cycles equals the memory's wait cycles plus one.
- R9: A read and a write requested in the same cycle start a read only. Requests made while busy are ignored. A bus load of MDR while busy is ignored. mem_read and mem_write are never high together.
- R10: The sequence (R1 out, Y in), (R2 out, add, Z in), (Z out, R3 in) leaves R3 = R1 + R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| out_en | input | 8 | Per-source bus drive enables |
| in_en | input | 10 | Per-sink bus load enables |
| alu_op | input | 3 | ALU operation code |
| sel_const4 | input | 1 | 1 selects constant 4 as ALU operand A, 0 selects Y |
| rd_req | input | 1 | Start a memory read at MAR |
| wr_req | input | 1 | Start a memory write of MDR at MAR |
| mem_rdata | input | DW | Read data from memory |
| mem_mfc | input | 1 | Memory reports that the access is complete |
| mem_addr | output | DW | Memory address (MAR) |
| mem_wdata | output | DW | Memory write data (MDR) |
| mem_read | output | 1 | Read access in progress |
| mem_write | output | 1 | Write access in progress |
| mem_busy | output | 1 | Memory machine not idle |
| mem_done | output | 1 | One-cycle pulse after an access completes |
| ir_value | output | DW | Instruction register contents, for the decoder |
| bus_value | output | DW | Current internal bus value |
| bus_conflict | output | 1 | More than one bus source is enabled |
| flag_neg | output | 1 | Sign of the last result loaded into Z |
| flag_zero | output | 1 | Last result loaded into Z was zero |

## Verification
The bench drives memory with waits of zero, one, three and five cycles. A machine that leaves its access state one cycle early or late shows a wrong strobe count, and one that misses a zero-wait completion hangs until the watchdog fires. It issues a read and a write in the same cycle, a write and an MDR bus load during a busy read, and ALU steps without a Z load. A design that lets a late request or a bus load through corrupts MDR or emits a write, and one that updates the flags on every cycle changes flag_zero. Two sources enabled at once must raise the conflict flag and give the OR value. Pointing the constant 4 at the wrong operand breaks the program counter increment.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
    localparam int SRC_R0  = 0;
    localparam int SRC_PC  = 4;
    localparam int SRC_IR  = 5;
    localparam int SRC_Z   = 6;
    localparam int SRC_MDR = 7;
    localparam int NSRC    = 8;

    localparam int DST_R0  = 0;
    localparam int DST_PC  = 4;
    localparam int DST_IR  = 5;
    localparam int DST_Y   = 6;
    localparam int DST_Z   = 7;
    localparam int DST_MAR = 8;
    localparam int DST_MDR = 9;
    localparam int NDST    = 10;

    localparam int NGPR    = 4;

    typedef enum logic [2:0] {
        ALU_ADD   = 3'd0,
        ALU_SUB   = 3'd1,
        ALU_AND   = 3'd2,
        ALU_OR    = 3'd3,
        ALU_PASSB = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_READ  = 2'd1,
        MS_WRITE = 2'd2
    } mem_state_e;
endpackage

// File: rtl/sbus_gpr.sv
module sbus_gpr #(
    parameter int DW   = 32,
    parameter int NREG = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [DW-1:0]             bus,
    input  logic [NREG-1:0]           load,
    output logic [NREG-1:0][DW-1:0]   q
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[g] <= '0;
            else if (load[g])
                q[g] <= bus;
        end
    end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [2:0]    op,
    output logic [DW-1:0] res
);
    always_comb begin
        case (alu_op_e'(op))
            ALU_ADD:   res = op_a + op_b;
            ALU_SUB:   res = op_a - op_b;
            ALU_AND:   res = op_a & op_b;
            ALU_OR:    res = op_a | op_b;
            ALU_PASSB: res = op_b;
            default:   res = op_b;
        endcase
    end
endmodule

// File: rtl/sbus_memctl.sv
module sbus_memctl
    import sbus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_req,
    input  logic wr_req,
    input  logic mfc,
    output logic mem_read,
    output logic mem_write,
    output logic busy,
    output logic capture,
    output logic done
);
    mem_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MS_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= (state != MS_IDLE) && mfc;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MS_IDLE: begin
                if (rd_req)      state_nx = MS_READ;
                else if (wr_req) state_nx = MS_WRITE;
            end
            MS_READ:  if (mfc) state_nx = MS_IDLE;
            MS_WRITE: if (mfc) state_nx = MS_IDLE;
            default:  state_nx = MS_IDLE;
        endcase
    end

    always_comb begin
        mem_read  = (state == MS_READ);
        mem_write = (state == MS_WRITE);
        busy      = (state != MS_IDLE);
        capture   = (state == MS_READ) && mfc;
    end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  out_en,
    input  logic [NDST-1:0]  in_en,
    input  logic [2:0]       alu_op,
    input  logic             sel_const4,
    input  logic             rd_req,
    input  logic             wr_req,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_mfc,
    output logic [DW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_read,
    output logic             mem_write,
    output logic             mem_busy,
    output logic             mem_done,
    output logic [DW-1:0]    ir_value,
    output logic [DW-1:0]    bus_value,
    output logic             bus_conflict,
    output logic             flag_neg,
    output logic             flag_zero
);
    localparam logic [DW-1:0] CONST4 = DW'(4);

    logic [NGPR-1:0][DW-1:0] gpr_q;
    logic [NSRC-1:0][DW-1:0] src;
    logic [DW-1:0] pc_q, ir_q, y_q, z_q, mar_q, mdr_q;
    logic [DW-1:0] alu_a, alu_res;
    logic          mdr_capture;

    for (genvar g = 0; g < NGPR; g++) begin : g_src
        assign src[SRC_R0 + g] = gpr_q[g];
    end
    assign src[SRC_PC]  = pc_q;
    assign src[SRC_IR]  = ir_q;
    assign src[SRC_Z]   = z_q;
    assign src[SRC_MDR] = mdr_q;

    always_comb begin
        bus_value = '0;
        for (int i = 0; i < NSRC; i++)
            if (out_en[i]) bus_value = bus_value | src[i];
    end
    assign bus_conflict = ($countones(out_en) > 1);

    sbus_gpr #(.DW(DW), .NREG(NGPR)) u_gpr (
        .clk  (clk),
        .rst  (rst),
        .bus  (bus_value),
        .load (in_en[DST_R0 +: NGPR]),
        .q    (gpr_q)
    );

    assign alu_a = sel_const4 ? CONST4 : y_q;

    sbus_alu #(.DW(DW)) u_alu (
        .op_a (alu_a),
        .op_b (bus_value),
        .op   (alu_op),
        .res  (alu_res)
    );

    sbus_memctl u_memctl (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .mfc       (mem_mfc),
        .mem_read  (mem_read),
        .mem_write (mem_write),
        .busy      (mem_busy),
        .capture   (mdr_capture),
        .done      (mem_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q      <= '0;
            ir_q      <= '0;
            y_q       <= '0;
            z_q       <= '0;
            mar_q     <= '0;
            mdr_q     <= '0;
            flag_neg  <= 1'b0;
            flag_zero <= 1'b0;
        end else begin
            if (in_en[DST_PC])  pc_q  <= bus_value;
            if (in_en[DST_IR])  ir_q  <= bus_value;
            if (in_en[DST_Y])   y_q   <= bus_value;
            if (in_en[DST_MAR]) mar_q <= bus_value;
            if (in_en[DST_Z]) begin
                z_q       <= alu_res;
                flag_neg  <= alu_res[DW-1];
                flag_zero <= (alu_res == '0);
            end
            if (mdr_capture)
                mdr_q <= mem_rdata;
            else if (in_en[DST_MDR] && !mem_busy)
                mdr_q <= bus_value;
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign ir_value  = ir_q;
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk
    import sbus_pkg::*;
#(
    parameter int DW = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] out_en,
    input logic [NDST-1:0] in_en,
    input logic            mem_mfc,
    input logic [DW-1:0]   mem_addr,
    input logic            mem_read,
    input logic            mem_write,
    input logic            mem_busy,
    input logic            mem_done,
    input logic [DW-1:0]   bus_value,
    input logic            bus_conflict,
    input logic            flag_neg,
    input logic            flag_zero
);
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_read && mem_write)); // R9

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_read && !mem_mfc) |=> mem_read); // R7

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        mem_done |-> ($past(mem_mfc) && $past(mem_busy))); // R7

    AST_MAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_en[DST_MAR] |=> $stable(mem_addr)); // R2

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_en[DST_Z] |=> ($stable(flag_neg) && $stable(flag_zero))); // R6

    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
        (out_en == '0) |-> (bus_value == '0)); // R3

    AST_MULTI_DRIVE: assert property (@(posedge clk) disable iff (rst)
        ($countones(out_en) >= 2) |-> bus_conflict); // R4
endmodule

bind sbus_datapath sbus_datapath_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .out_en       (out_en),
    .in_en        (in_en),
    .mem_mfc      (mem_mfc),
    .mem_addr     (mem_addr),
    .mem_read     (mem_read),
    .mem_write    (mem_write),
    .mem_busy     (mem_busy),
    .mem_done     (mem_done),
    .bus_value    (bus_value),
    .bus_conflict (bus_conflict),
    .flag_neg     (flag_neg),
    .flag_zero    (flag_zero)
);

// File: tb/test_sbus_datapath.sv
module test_sbus_datapath;
    import sbus_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic [NSRC-1:0] out_en = '0;
    logic [NDST-1:0] in_en = '0;
    logic [2:0]      alu_op = '0;
    logic            sel_const4 = 1'b0;
    logic            rd_req = 1'b0;
    logic            wr_req = 1'b0;
    logic [DW-1:0]   mem_rdata = '0;
    logic            mem_mfc = 1'b0;
    logic [DW-1:0]   mem_addr, mem_wdata, ir_value, bus_value;
    logic            mem_read, mem_write, mem_busy, mem_done;
    logic            bus_conflict, flag_neg, flag_zero;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [DW-1:0] mem [16];
    int lat = 0;
    int wcnt = 0;
    int rd_cycles = 0;
    int wr_cycles = 0;

    sbus_datapath #(.DW(DW)) i_sbus_datapath (
        .clk(clk), .rst(rst), .out_en(out_en), .in_en(in_en), .alu_op(alu_op),
        .sel_const4(sel_const4), .rd_req(rd_req), .wr_req(wr_req),
        .mem_rdata(mem_rdata), .mem_mfc(mem_mfc), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_read(mem_read), .mem_write(mem_write),
        .mem_busy(mem_busy), .mem_done(mem_done), .ir_value(ir_value),
        .bus_value(bus_value), .bus_conflict(bus_conflict),
        .flag_neg(flag_neg), .flag_zero(flag_zero)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model with programmable wait cycles, acting on the falling edge
    always @(negedge clk) begin
        if (mem_read)  rd_cycles++;
        if (mem_write) wr_cycles++;
        if (mem_mfc) begin
            mem_mfc = 1'b0;
        end else if (mem_read || mem_write) begin
            if (wcnt >= lat) begin
                if (mem_write) mem[mem_addr[5:2]] = mem_wdata;
                mem_rdata = mem[mem_addr[5:2]];
                mem_mfc = 1'b1;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    function automatic logic [NSRC-1:0] om(int s);
        return NSRC'(1) << s;
    endfunction
    function automatic logic [NDST-1:0] im(int d);
        return NDST'(1) << d;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(logic [NSRC-1:0] o, logic [NDST-1:0] i, logic [2:0] op, logic s4);
        out_en = o; in_en = i; alu_op = op; sel_const4 = s4;
        @(posedge clk); @(negedge clk);
        out_en = '0; in_en = '0; alu_op = '0; sel_const4 = 1'b0;
    endtask

    task automatic peek(logic [NSRC-1:0] o, output logic [DW-1:0] v);
        out_en = o; #1; v = bus_value; out_en = '0;
    endtask

    task automatic mem_op(logic rd, logic wr);
        int waited = 0;
        rd_req = rd; wr_req = wr;
        @(posedge clk); @(negedge clk);
        rd_req = 1'b0; wr_req = 1'b0;
        while (!mem_done && waited < 100) begin
            @(negedge clk); waited++;
        end
    endtask

    task automatic set_mar(int k);
        if (k == 0) begin
            cyc('0, im(DST_MAR), ALU_ADD, 1'b0);
        end else begin
            cyc('0, im(DST_Z), ALU_ADD, 1'b1);
            for (int j = 1; j < k; j++) cyc(om(SRC_Z), im(DST_Z), ALU_ADD, 1'b1);
            cyc(om(SRC_Z), im(DST_MAR), ALU_ADD, 1'b0);
        end
    endtask

    task automatic load_reg(int k, int dst);
        set_mar(k);
        mem_op(1'b1, 1'b0);
        cyc(om(SRC_MDR), im(dst), ALU_ADD, 1'b0);
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        peek('0, v);          check("R1 bus idle", v, 0);
        peek(om(SRC_PC), v);  check("R1 PC", v, 0);
        peek(om(SRC_Z), v);   check("R1 Z", v, 0);
        peek(om(SRC_MDR), v); check("R1 MDR", v, 0);
        peek(om(1), v);       check("R1 R1", v, 0);
        check("R1 MAR", mem_addr, 0);
        check("R1 IR", ir_value, 0);
        check("R1 busy/done/rd/wr/flags",
              {mem_busy, mem_done, mem_read, mem_write, flag_neg, flag_zero}, 0);
    endtask

    task automatic t_load;
        logic [DW-1:0] v;
        lat = 2;
        load_reg(1, DST_R0 + 1);
        load_reg(2, DST_R0 + 2);
        peek(om(1), v); check("R7 load R1 via MDR", v, 100);
        peek(om(2), v); check("R7 load R2 via MDR", v, 250);
        @(negedge clk);
        check("R7 done one cycle", {mem_done, mem_busy}, 0);
    endtask

    task automatic t_add;
        logic [DW-1:0] v;
        cyc(om(1), im(DST_Y), ALU_ADD, 1'b0);
        cyc(om(2), im(DST_Z), ALU_ADD, 1'b0);
        cyc(om(SRC_Z), im(3), ALU_ADD, 1'b0);
        peek(om(3), v); check("R10 R3=R1+R2", v, 350);
        check("R6 flags after add", {flag_neg, flag_zero}, 2'b00);
    endtask

    task automatic t_alu;
        logic [DW-1:0] v;
        cyc(om(1), im(DST_Y), ALU_ADD, 1'b0);
        cyc(om(2), im(DST_Z), ALU_SUB, 1'b0);
        peek(om(SRC_Z), v); check("R5 sub", v, 32'hFFFF_FF6A);
        check("R6 negative flag", {flag_neg, flag_zero}, 2'b10);
        cyc(om(2), im(DST_Z), ALU_AND, 1'b0);
        peek(om(SRC_Z), v); check("R5 and", v, 32'h60);
        cyc(om(2), im(DST_Z), ALU_OR, 1'b0);
        peek(om(SRC_Z), v); check("R5 or", v, 32'hFE);
        cyc(om(2), im(DST_Z), ALU_PASSB, 1'b0);
        peek(om(SRC_Z), v); check("R5 pass B", v, 250);
        cyc(om(1), im(DST_Z), ALU_SUB, 1'b0);
        check("R6 zero flag", {flag_neg, flag_zero}, 2'b01);
        cyc(om(2), '0, ALU_ADD, 1'b0);
        peek(om(SRC_Z), v); check("R5 Z holds without load", v, 0);
        check("R6 flags hold without load", {flag_neg, flag_zero}, 2'b01);
    endtask

    task automatic t_const4;
        logic [DW-1:0] v;
        for (int j = 0; j < 2; j++) begin
            cyc(om(SRC_PC), im(DST_Z), ALU_ADD, 1'b1);
            cyc(om(SRC_Z), im(DST_PC), ALU_ADD, 1'b0);
        end
        peek(om(SRC_PC), v); check("R5 PC advanced by constant 4 twice", v, 8);
        cyc(om(2), im(DST_Z), ALU_ADD, 1'b1);
        peek(om(SRC_Z), v); check("R5 constant 4 plus bus", v, 254);
    endtask

    task automatic t_conflict;
        out_en = om(1) | om(2); #1;
        check("R4 conflict flag", bus_conflict, 1);
        check("R4 OR of sources", bus_value, 32'hFE);
        out_en = om(3); #1;
        check("R4 no conflict single", bus_conflict, 0);
        check("R3 single source", bus_value, 350);
        out_en = '0;
    endtask

    task automatic t_isolate;
        logic [DW-1:0] v;
        cyc(om(1), im(DST_R0), ALU_ADD, 1'b0);
        peek(om(0), v); check("R2 R0 loaded", v, 100);
        peek(om(2), v); check("R2 R2 untouched", v, 250);
        peek(om(3), v); check("R2 R3 untouched", v, 350);
        check("R2 IR untouched", ir_value, 0);
        cyc(om(3), im(DST_IR), ALU_ADD, 1'b0);
        check("R2 IR loaded", ir_value, 350);
    endtask

    task automatic t_write;
        lat = 3;
        set_mar(5);
        cyc(om(3), im(DST_MDR), ALU_ADD, 1'b0);
        check("R8 address MAR", mem_addr, 20);
        check("R8 write data MDR", mem_wdata, 350);
        wr_cycles = 0; rd_cycles = 0;
        mem_op(1'b0, 1'b1);
        check("R8 stored word", mem[5], 350);
        check("R8 write strobe cycles", wr_cycles, lat + 1);
        check("R8 no read strobe", rd_cycles, 0);
    endtask

    task automatic t_read_lat;
        logic [DW-1:0] v;
        lat = 0;
        set_mar(3);
        rd_cycles = 0;
        mem_op(1'b1, 1'b0);
        peek(om(SRC_MDR), v); check("R7 zero-wait read", v, 32'hF0F0_1234);
        check("R7 zero-wait strobe cycles", rd_cycles, 1);
        lat = 5;
        set_mar(4);
        rd_cycles = 0; wr_cycles = 0;
        rd_req = 1'b1; @(posedge clk); @(negedge clk); rd_req = 1'b0;
        wr_req = 1'b1;
        cyc(om(1), im(DST_MDR), ALU_ADD, 1'b0);
        wr_req = 1'b0;
        while (!mem_done) @(negedge clk);
        peek(om(SRC_MDR), v); check("R9 MDR bus load while busy ignored", v, 32'h0FF0_FFFF);
        check("R9 write while busy ignored", wr_cycles, 0);
        check("R7 long-wait strobe cycles", rd_cycles, 6);
    endtask

    task automatic t_prio;
        logic [DW-1:0] v;
        lat = 1;
        set_mar(2);
        rd_cycles = 0; wr_cycles = 0;
        mem_op(1'b1, 1'b1);
        check("R9 read wins, no write", wr_cycles, 0);
        check("R9 read strobe cycles", rd_cycles, 2);
        peek(om(SRC_MDR), v); check("R9 read data", v, 250);
    endtask

    initial begin
        for (int j = 0; j < 16; j++) mem[j] = '0;
        mem[1] = 100; mem[2] = 250; mem[3] = 32'hF0F0_1234; mem[4] = 32'h0FF0_FFFF;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset;
        t_load;
        t_add;
        t_alu;
        t_const4;
        t_conflict;
        t_isolate;
        t_write;
        t_read_lat;
        t_prio;
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog R7: actual hung expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule